// File: doc/BRIEF.md
# Debug-mode core clock switch

This block picks which of two clocks drives the processor core. In normal running the core takes the free-running memory clock. When a debug-entry request arrives, the block raises a debug acknowledge on a rising edge of the memory clock, while that clock is high. It stops passing memory-clock pulses from the following falling edge and then hands the core over to the debug clock, with no action needed from the debugger.

While debugging, the core stays on the debug clock whatever the request and restart inputs do. Leaving debug is a two-step sequence, both steps sampled on rising edges of the debug clock. First the strobe marking the final debug-clocked instruction arrives. After that, the restart strobe decoded from the test access port instruction register. The block then releases the debug clock and returns to the memory clock on its own. The acknowledge drops only once memory-clock pulses reach the core again.

Each handover is break-before-make: both gate enables are low for at least one full period of the clock being released, and each side only reacts to a synchronized view of the other side's enable. The number of synchronizer stages and the length of the release guard are parameters.

Top module: `dbg_clk_switch`

## Requirements
- R1: While reset is low and right after it rises, the core clock follows the memory clock, dbg_ack is 0 and clk_sel_dbg is 0 (0 = memory clock, 1 = debug clock).
- R2: dbg_req is sampled on rising edges of mclk. dbg_ack rises on the first rising mclk edge that sees it high, so dbg_ack goes high while mclk is high.
- R3: After dbg_ack rises, no memory-clock pulse starts on core_clk. The pulse that began at the edge where dbg_ack rose is the last one, and it ends at the next falling mclk edge.
- R4: After entry, core_clk carries debug-clock pulses only. While in debug it stays on the debug clock whatever dbg_req does.
- R5: Exit needs last_instr_stb and then restart_stb, both sampled on rising dclk edges, in that order, within the current debug session. A restart with no earlier last-instruction strobe in that session is ignored, and so is a last-instruction strobe alone.
- R6: last_instr_stb and restart_stb have no effect while not in debug state. The core clock stays on mclk and dbg_ack and clk_sel_dbg stay 0.
- R7: After a valid exit sequence, the block returns the core to the memory clock with no further input. It can enter debug again later.
- R8: dbg_ack falls only once core_clk is again carrying memory-clock pulses. It falls at a rising mclk edge where a memory pulse starts on core_clk.
- R9: Every high pulse on core_clk is one whole high phase of mclk or of dclk, and every low gap is at least one half period of mclk. There are no runt or merged pulses.
- R10: When the source changes, the low gap on core_clk between the last pulse of the old clock and the first pulse of the new one is at least one full period of the old clock.
- R11: clk_sel_dbg rises only after memory pulses have stopped, and falls at a rising mclk edge where a memory pulse starts on core_clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Free-running memory (functional) clock |
| dclk | input | 1 | Debug clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| dbg_req | input | 1 | Debug-entry request, sampled on rising mclk |
| last_instr_stb | input | 1 | Final debug instruction clocked in, sampled on rising dclk |
| restart_stb | input | 1 | Restart code decoded in the instruction register, sampled on rising dclk |
| core_clk | output | 1 | Gated core clock |
| dbg_ack | output | 1 | Debug acknowledge |
| clk_sel_dbg | output | 1 | Current core clock source: 0 memory, 1 debug |

## Verification
The hard part to reach from the ports is the exit ordering. A restart strobe must be rejected when it comes without a preceding last-instruction strobe in the same session, and again when the block is idle. A leftover arming from earlier activity must not let a later restart through. The stimulus sends restarts in idle mode, then a stray restart and a lone last-instruction strobe during debug, and only then the real restart. It runs two full sessions so that stale state from the first would show in the second. Every core_clk pulse is timed against both clock half periods, so a runt pulse, a merged pulse or a short handover gap is caught.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
   typedef enum logic {
      SRC_MEM = 1'b0,
      SRC_DBG = 1'b1
   } clk_src_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_GUARD       = 1;
endpackage

// File: rtl/dcs_sync.sv
`timescale 1ns/1ps
module dcs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import dcs_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("dcs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dcs_gate.sv
`timescale 1ns/1ps
module dcs_gate #(
   parameter int unsigned STAGES   = 2,
   parameter int unsigned GUARD    = 1,
   parameter logic        START_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic want,
   input  logic other_busy,
   output logic en,
   output logic busy,
   output logic other_seen
);
   import dcs_pkg::*;

   if (GUARD < MIN_GUARD) begin : g_bad_guard
      $error("dcs_gate: GUARD must be at least 1");
   end

   logic             en_q;
   logic [GUARD-1:0] hist;

   dcs_sync #(.STAGES(STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (other_busy),
      .q    (other_seen)
   );

   // enable changes only on the falling edge, while this clock is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= START_ON;
      else        en_q <= want & ~other_seen;
   end

   if (GUARD == 1) begin : g_guard_one
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) hist <= START_ON;
         else        hist <= en_q;
      end
   end else begin : g_guard_chain
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) hist <= {GUARD{START_ON}};
         else        hist <= {hist[GUARD-2:0], en_q};
      end
   end

   assign en   = en_q;
   assign busy = en_q | (|hist);
endmodule

// File: rtl/dcs_mem_ctrl.sv
`timescale 1ns/1ps
module dcs_mem_ctrl #(
   parameter int unsigned STAGES = 2
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              dbg_req,
   input  logic              rel_async,
   input  logic              en_m,
   input  logic              dbg_seen,
   output logic              ack,
   output logic              want_m,
   output dcs_pkg::clk_src_e sel
);
   import dcs_pkg::*;

   logic rel_m;

   dcs_sync #(.STAGES(STAGES)) u_rel_sync (
      .clk  (mclk),
      .rst_n(rst_n),
      .d    (rel_async),
      .q    (rel_m)
   );

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         ack <= 1'b0;
      end else if (!ack && dbg_req && !rel_m) begin
         ack <= 1'b1;
      end else if (ack && rel_m && en_m) begin
         ack <= 1'b0;
      end
   end

   assign want_m = ~ack | rel_m;

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n)        sel <= SRC_MEM;
      else if (en_m)     sel <= SRC_MEM;
      else if (dbg_seen) sel <= SRC_DBG;
   end

   // R8: acknowledge drops only with the memory gate open
   assert_ack_after_return_R8: assert property (@(posedge mclk) disable iff (!rst_n)
      $fell(ack) |-> en_m);
endmodule

// File: rtl/dcs_dbg_ctrl.sv
`timescale 1ns/1ps
module dcs_dbg_ctrl #(
   parameter int unsigned STAGES = 2
) (
   input  logic dclk,
   input  logic rst_n,
   input  logic ack_async,
   input  logic last_instr_stb,
   input  logic restart_stb,
   output logic want_d,
   output logic rel_d
);
   logic ack_d;
   logic armed;

   dcs_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk  (dclk),
      .rst_n(rst_n),
      .d    (ack_async),
      .q    (ack_d)
   );

   always_ff @(posedge dclk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         rel_d <= 1'b0;
      end else if (!ack_d) begin
         armed <= 1'b0;
         rel_d <= 1'b0;
      end else begin
         if (!rel_d && last_instr_stb) armed <= 1'b1;
         if (!rel_d && armed && restart_stb) rel_d <= 1'b1;
      end
   end

   assign want_d = ack_d & ~rel_d;

   // R5: restart without prior last-instruction strobe does not release
   assert_restart_needs_arm_R5: assert property (@(posedge dclk) disable iff (!rst_n)
      (restart_stb && !armed && !rel_d) |=> !rel_d);

   // R6: no arming outside a debug session
   assert_idle_no_arm_R6: assert property (@(posedge dclk) disable iff (!rst_n)
      !ack_d |=> (!armed && !rel_d));
endmodule

// File: rtl/dbg_clk_switch.sv
`timescale 1ns/1ps
module dbg_clk_switch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GUARD_M     = 1,
   parameter int unsigned GUARD_D     = 1
) (
   input  logic mclk,
   input  logic dclk,
   input  logic rst_n,
   input  logic dbg_req,
   input  logic last_instr_stb,
   input  logic restart_stb,
   output logic core_clk,
   output logic dbg_ack,
   output logic clk_sel_dbg
);
   import dcs_pkg::*;

   logic     en_m, en_d;
   logic     busy_m, busy_d;
   logic     seen_d_in_m, seen_m_in_d;
   logic     want_m, want_d;
   logic     ack, rel_d;
   clk_src_e sel;

   dcs_mem_ctrl #(.STAGES(SYNC_STAGES)) u_mem_ctrl (
      .mclk     (mclk),
      .rst_n    (rst_n),
      .dbg_req  (dbg_req),
      .rel_async(rel_d),
      .en_m     (en_m),
      .dbg_seen (seen_d_in_m),
      .ack      (ack),
      .want_m   (want_m),
      .sel      (sel)
   );

   dcs_dbg_ctrl #(.STAGES(SYNC_STAGES)) u_dbg_ctrl (
      .dclk          (dclk),
      .rst_n         (rst_n),
      .ack_async     (ack),
      .last_instr_stb(last_instr_stb),
      .restart_stb   (restart_stb),
      .want_d        (want_d),
      .rel_d         (rel_d)
   );

   dcs_gate #(.STAGES(SYNC_STAGES), .GUARD(GUARD_M), .START_ON(1'b1)) u_gate_m (
      .clk       (mclk),
      .rst_n     (rst_n),
      .want      (want_m),
      .other_busy(busy_d),
      .en        (en_m),
      .busy      (busy_m),
      .other_seen(seen_d_in_m)
   );

   dcs_gate #(.STAGES(SYNC_STAGES), .GUARD(GUARD_D), .START_ON(1'b0)) u_gate_d (
      .clk       (dclk),
      .rst_n     (rst_n),
      .want      (want_d),
      .other_busy(busy_m),
      .en        (en_d),
      .busy      (busy_d),
      .other_seen(seen_m_in_d)
   );

   assign core_clk    = (mclk & en_m) | (dclk & en_d);
   assign dbg_ack     = ack;
   assign clk_sel_dbg = (sel == SRC_DBG);

   // R10: the two gates are never open together
   always_comb begin
      if (rst_n) begin
         assert_no_overlap_R10: assert (!(en_m && en_d));
      end
   end

   // R3: memory gate closes at the falling edge after acknowledge
   assert_switch_on_fall_R3: assert property (@(negedge mclk) disable iff (!rst_n)
      $rose(ack) |=> !en_m);

   // R4: debug gate stays open until a release is accepted
   assert_hold_debug_R4: assert property (@(posedge dclk) disable iff (!rst_n)
      (en_d && !rel_d && !restart_stb) |=> en_d);

   // R11: debug status only once the memory gate is closed
   assert_status_after_handover_R11: assert property (@(posedge mclk) disable iff (!rst_n)
      $rose(clk_sel_dbg) |-> !en_m);
endmodule

// File: tb/dbg_clk_switch_bench.sv
`timescale 1ns/1ps
module dbg_clk_switch_bench;
   logic mclk = 1'b0;
   logic dclk = 1'b0;
   logic rst_n = 1'b0;
   logic dbg_req = 1'b0;
   logic last_instr_stb = 1'b0;
   logic restart_stb = 1'b0;
   logic core_clk, dbg_ack, clk_sel_dbg;

   int n_cmp = 0;
   int n_bad = 0;
   int n_short = 0;
   int n_long = 0;
   int prev_kind = 0;
   bit settled = 1'b0;
   bit exp_dbg = 1'b0;
   bit done = 1'b0;
   realtime t_rise = 0.0;
   realtime last_fall = -100.0;
   realtime last_short_start = -1.0;
   realtime last_long_start = -1.0;
   realtime t_ack = 0.0;
   realtime t_req = 0.0;

   dbg_clk_switch u_dbg_clk_switch (
      .mclk          (mclk),
      .dclk          (dclk),
      .rst_n         (rst_n),
      .dbg_req       (dbg_req),
      .last_instr_stb(last_instr_stb),
      .restart_stb   (restart_stb),
      .core_clk      (core_clk),
      .dbg_ack       (dbg_ack),
      .clk_sel_dbg   (clk_sel_dbg)
   );

   always #5 mclk = ~mclk;
   initial begin
      #3;
      forever #17 dclk = ~dclk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit near(input realtime a, input realtime b);
      return (a > b - 0.2) && (a < b + 0.2);
   endfunction

   // pulse timing monitor: R9, R10
   always @(posedge core_clk) t_rise = $realtime;
   always @(negedge core_clk) begin
      realtime w, gap;
      int kind;
      w = $realtime - t_rise;
      gap = t_rise - last_fall;
      kind = near(w, 5.0) ? 1 : (near(w, 17.0) ? 2 : 0);
      chk(kind != 0, "R9", "pulse width ps", int'(w * 1000.0), 5000);
      chk(gap > 4.8, "R9", "low gap ps", int'(gap * 1000.0), 5000);
      if (kind != 0 && prev_kind != 0 && kind != prev_kind)
         chk(gap > ((prev_kind == 1) ? 9.8 : 33.8), "R10", "handover gap ps",
             int'(gap * 1000.0), (prev_kind == 1) ? 10000 : 34000);
      if (kind == 1) begin n_short++; last_short_start = t_rise; end
      if (kind == 2) begin n_long++;  last_long_start  = t_rise; end
      if (kind != 0) prev_kind = kind;
      last_fall = $realtime;
   end

   // acknowledge edges: R2, R8
   always @(posedge dbg_ack) begin
      t_ack = $realtime;
      chk(mclk === 1'b1, "R2", "mclk at ack rise", int'(mclk), 1);
      chk(near(t_ack - t_req, 5.0), "R2", "ack latency ps",
          int'((t_ack - t_req) * 1000.0), 5000);
   end
   always @(negedge dbg_ack) begin
      if (rst_n) begin
         #0.5;
         chk(core_clk === 1'b1 && mclk === 1'b1, "R8", "memory pulse at ack fall",
             int'(core_clk), 1);
      end
   end

   // status edges: R11
   always @(posedge clk_sel_dbg) begin
      chk(last_short_start <= t_ack + 0.5, "R11", "no memory pulse after ack",
          int'(last_short_start), int'(t_ack));
      chk(dbg_ack === 1'b1, "R11", "ack at status rise", int'(dbg_ack), 1);
   end
   always @(negedge clk_sel_dbg) begin
      if (rst_n) begin
         #0.5;
         chk(core_clk === 1'b1 && mclk === 1'b1, "R11", "memory pulse at status fall",
             int'(core_clk), 1);
      end
   end

   // reference mode compared on every memory-clock cycle
   always @(negedge mclk) begin
      if (settled && !done) begin
         chk(dbg_ack === exp_dbg, exp_dbg ? "R4" : "R7", "model ack",
             int'(dbg_ack), int'(exp_dbg));
         chk(clk_sel_dbg === exp_dbg, exp_dbg ? "R4" : "R7", "model status",
             int'(clk_sel_dbg), int'(exp_dbg));
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic pulse_req();
      @(negedge mclk);
      dbg_req = 1'b1;
      t_req = $realtime;
      @(negedge mclk);
      dbg_req = 1'b0;
   endtask

   task automatic pulse_last();
      @(negedge dclk);
      last_instr_stb = 1'b1;
      @(negedge dclk);
      last_instr_stb = 1'b0;
   endtask

   task automatic pulse_restart();
      @(negedge dclk);
      restart_stb = 1'b1;
      @(negedge dclk);
      restart_stb = 1'b0;
   endtask

   task automatic window(input int n);
      @(negedge mclk);
      #1;
      n_short = 0;
      n_long = 0;
      repeat (n) @(negedge mclk);
      #1;
   endtask

   task automatic session(input int round);
      // entry: R2 checked by monitor, R3 and R4 here
      settled = 1'b0;
      exp_dbg = 1'b1;
      pulse_req();
      repeat (60) @(negedge mclk);
      settled = 1'b1;
      chk(last_short_start <= t_ack + 0.5, "R3", "last memory pulse vs ack",
          int'(last_short_start), int'(t_ack));
      chk(clk_sel_dbg === 1'b1, "R4", "status after entry", int'(clk_sel_dbg), 1);
      window(40);
      chk(n_short == 0, "R4", "memory pulses in debug", n_short, 0);
      chk(n_long >= 10, "R4", "debug pulses in debug", n_long, 11);
      // stray request and stray restart during debug: R4, R5
      pulse_req();
      pulse_restart();
      window(40);
      chk(dbg_ack === 1'b1 && n_short == 0, "R5", "stray restart ignored",
          n_short, 0);
      // last-instruction strobe alone: R5
      pulse_last();
      window(40);
      chk(dbg_ack === 1'b1 && clk_sel_dbg === 1'b1 && n_short == 0, "R5",
          "last strobe alone keeps debug", int'(clk_sel_dbg), 1);
      // valid restart: R7
      settled = 1'b0;
      exp_dbg = 1'b0;
      pulse_restart();
      repeat (80) @(negedge mclk);
      settled = 1'b1;
      chk(dbg_ack === 1'b0, "R7", "ack after exit", int'(dbg_ack), 0);
      chk(clk_sel_dbg === 1'b0, "R7", "status after exit", int'(clk_sel_dbg), 0);
      window(20);
      chk(n_short == 20 && n_long == 0, "R7", "memory pulses after exit",
          n_short, 20 + round * 0);
   endtask

   initial begin
      repeat (5) @(negedge mclk);
      rst_n = 1'b1;
      #1;
      chk(dbg_ack === 1'b0, "R1", "ack after reset", int'(dbg_ack), 0);
      chk(clk_sel_dbg === 1'b0, "R1", "status after reset", int'(clk_sel_dbg), 0);
      window(10);
      chk(n_short == 10 && n_long == 0, "R1", "memory pulses after reset", n_short, 10);
      exp_dbg = 1'b0;
      settled = 1'b1;
      // idle strobes: R6
      pulse_last();
      pulse_restart();
      pulse_restart();
      window(40);
      chk(dbg_ack === 1'b0 && clk_sel_dbg === 1'b0, "R6", "idle strobes ignored",
          int'(dbg_ack), 0);
      chk(n_short == 40 && n_long == 0, "R6", "memory pulses after idle strobes",
          n_short, 40);
      session(1);
      session(2);
      finish_run();
   end

   initial begin
      #100us;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule